// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the byte-level front end of a two-wire serial memory slave. During a write transaction it gathers the data bytes into a small page buffer. A byte lands in the buffer only once its acknowledge phase has finished. The buffer slot is chosen by a byte pointer that wraps inside the page, so a master may begin at any byte. When a transaction carries more bytes than the page holds, the later bytes replace the earlier ones in order.

At the stop event the block decides whether the transaction counts. It commits only if three things hold: at least one byte completed together with its acknowledge, no byte was left half-received, and write protect was low when the transaction began. On a commit, a busy period of fixed length starts. During that period the bytes that were loaded are copied to the array write port in ascending byte order. All bus-side input is ignored until busy ends.

The address counter stays inside the page that was addressed and points one past the last byte accepted. A later current-address access continues from there.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and `addr_ctr_o` is zero.
- R2: An address load inside an open transaction sets `addr_ctr_o` to `addr_i`. Bits [14:6] are the page and bits [5:0] are the byte within it.
- R3: Each acknowledged byte is stored at the current byte pointer. The pointer then advances by one and wraps from 63 to 0. The page bits never change during loading.
- R4: Loading more than 64 bytes overwrites earlier slots in load order. For example, starting at byte 32 with 64 bytes fills slots 32..63 and then 0..31, and leaves the pointer at 32.
- R5: A qualifying stop raises `busy_o` one cycle later and keeps it high for exactly BUSY_CYC cycles. During that period, each slot loaded in the transaction is written once to the array, at address {page, slot}, in ascending slot order. No other slot is written.
- R6: A stop that arrives before any byte has completed its acknowledge starts no busy period and writes nothing.
- R7: A stop that arrives after data bits of a byte but before that byte's acknowledge discards the whole transaction: there is no busy period and no array write.
- R8: Write protect is sampled at the start event. If it was high, the stop writes nothing and starts no busy period. Changes on `wp_i` after the start event have no effect.
- R9: While `busy_o` is high, the start, address-load, data, acknowledge and stop inputs are ignored. `addr_ctr_o` stays fixed, and no new transaction opens.
- R10: `arr_we_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start event pulse; opens a transaction and clears the buffer |
| wp_i | input | 1 | Write-protect level, sampled at start |
| addr_load_i | input | 1 | Word address received pulse |
| addr_i | input | 15 | Word address: page [14:6], byte [5:0] |
| data_bit_i | input | 1 | Pulse for each data bit sampled |
| byte_vld_i | input | 1 | Full byte received (eighth bit) |
| byte_i | input | 8 | Received byte, valid with byte_vld_i |
| byte_ack_i | input | 1 | Acknowledge phase of the held byte completed |
| stop_i | input | 1 | Stop event pulse |
| busy_o | output | 1 | Internal write period in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 15 | Array write address |
| arr_wdata_o | output | 8 | Array write data |
| addr_ctr_o | output | 15 | Current address counter |

## Verification
The bench builds the block with the default 9-bit page field and 6-bit byte field, so the wrap from slot 63 to slot 0 and loads longer than 64 bytes occur in ordinary stimulus. BUSY_CYC is set to 80 instead of a millisecond-scale count. This makes every busy period short enough to measure exactly and still leaves room for the full 64-slot copy. With these values, many random transactions can run, each with a random start address, byte count, protect level and abort point. Beside them, directed cases cover overwrite past 64 bytes, aborts in the middle of a byte, and input arriving during busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // Phases of the bus-side transaction as seen by this block
  typedef enum logic [1:0] {
    TXN_IDLE = 2'd0,
    TXN_OPEN = 2'd1
  } txn_e;

  // Decide whether a stop event may commit the gathered page
  function automatic logic stop_commits(input logic have_byte, input logic partial,
                                        input logic prot);
    return have_byte && !partial && !prot;
  endfunction
endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr #(
  parameter int PAGE_W = 9,
  parameter int BYTE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [PAGE_W+BYTE_W-1:0] addr_i,
  input  logic                     inc_i,
  output logic [PAGE_W+BYTE_W-1:0] addr_o
);
  localparam int ADDR_W = PAGE_W + BYTE_W;

  logic [PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:BYTE_W];
      ptr_q  <= addr_i[BYTE_W-1:0];
    end else if (inc_i) begin
      ptr_q <= ptr_q + 1'b1;  // wraps inside the page
    end
  end

  assign addr_o = {page_q, ptr_q};

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && ptr_q == {BYTE_W{1'b1}}) |=> (ptr_q == '0));
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> $stable(page_q));
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int BYTE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  localparam int DEPTH = 1 << BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  // Data storage: plain synchronous write / registered read
  always_ff @(posedge clk) begin
    if (wr_i) mem[wr_idx_i] <= wr_data_i;
    if (rd_i) rd_data_o <= mem[rd_idx_i];
  end

  // Per-slot loaded mask
  always_ff @(posedge clk) begin
    if (rst || clr_i) mask_q <= '0;
    else if (wr_i)    mask_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_o <= 1'b0;
    else     rd_vld_o <= rd_i && mask_q[rd_idx_i];
  end

  // R9
  no_load_during_copy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_i |-> !wr_i);
endmodule

// File: rtl/pgw_busy_timer.sv
module pgw_busy_timer #(
  parameter int LEN = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(LEN - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // Checker-side length counter
  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                       run_q <= '0;
    else if (go_i && !busy_o)      run_q <= CW'(1);
    else if (busy_o && cnt_q != 0) run_q <= run_q + 1'b1;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_q == CW'(LEN)));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int PAGE_W   = 9,
  parameter int BYTE_W   = 6,
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 500000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     wp_i,
  input  logic                     addr_load_i,
  input  logic [PAGE_W+BYTE_W-1:0] addr_i,
  input  logic                     data_bit_i,
  input  logic                     byte_vld_i,
  input  logic [DATA_W-1:0]        byte_i,
  input  logic                     byte_ack_i,
  input  logic                     stop_i,
  output logic                     busy_o,
  output logic                     arr_we_o,
  output logic [PAGE_W+BYTE_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0]        arr_wdata_o,
  output logic [PAGE_W+BYTE_W-1:0] addr_ctr_o
);
  import pgw_pkg::*;

  localparam int ADDR_W   = PAGE_W + BYTE_W;
  localparam int PG_BYTES = 1 << BYTE_W;
  // The busy window must cover the whole copy scan plus its output stage
  localparam int BUSY_LEN = (BUSY_CYC > PG_BYTES + 1) ? BUSY_CYC : PG_BYTES + 1;

  txn_e              txn_q;
  logic              wp_q;
  logic              partial_q;
  logic              have_q;
  logic              hold_v_q;
  logic [DATA_W-1:0] hold_q;
  logic              scan_q;
  logic [BYTE_W-1:0] idx_q;

  logic accept, open_ev, ld_ev, bit_ev, vld_ev, ack_ev, stop_ev, commit;

  assign accept  = !busy_o;
  assign open_ev = accept && start_i;
  assign ld_ev   = accept && !start_i && (txn_q == TXN_OPEN) && addr_load_i;
  assign bit_ev  = accept && !start_i && (txn_q == TXN_OPEN) && data_bit_i;
  assign vld_ev  = accept && !start_i && (txn_q == TXN_OPEN) && byte_vld_i;
  assign ack_ev  = accept && !start_i && (txn_q == TXN_OPEN) && byte_ack_i && hold_v_q;
  assign stop_ev = accept && !start_i && (txn_q == TXN_OPEN) && stop_i;
  assign commit  = stop_ev && stop_commits(have_q, partial_q, wp_q);

  // Transaction bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      txn_q     <= TXN_IDLE;
      wp_q      <= 1'b0;
      partial_q <= 1'b0;
      have_q    <= 1'b0;
      hold_v_q  <= 1'b0;
      hold_q    <= '0;
    end else if (open_ev) begin
      txn_q     <= TXN_OPEN;
      wp_q      <= wp_i;
      partial_q <= 1'b0;
      have_q    <= 1'b0;
      hold_v_q  <= 1'b0;
    end else if (stop_ev) begin
      txn_q     <= TXN_IDLE;
      partial_q <= 1'b0;
      hold_v_q  <= 1'b0;
    end else begin
      if (vld_ev) begin
        hold_q   <= byte_i;
        hold_v_q <= 1'b1;
      end
      if (ack_ev) begin
        hold_v_q  <= 1'b0;
        partial_q <= 1'b0;
        have_q    <= 1'b1;
      end else if (bit_ev || vld_ev) begin
        partial_q <= 1'b1;
      end
    end
  end

  // Copy scan over all slots during busy
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= 1'b0;
      idx_q  <= '0;
    end else if (commit) begin
      scan_q <= 1'b1;
      idx_q  <= '0;
    end else if (scan_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == {BYTE_W{1'b1}}) scan_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         arr_addr_o <= '0;
    else if (scan_q) arr_addr_o <= {addr_ctr_o[ADDR_W-1:BYTE_W], idx_q};
  end

  pgw_addr_ctr #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load_i (ld_ev),
    .addr_i (addr_i),
    .inc_i  (ack_ev),
    .addr_o (addr_ctr_o)
  );

  pgw_page_buf #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (open_ev),
    .wr_i      (ack_ev),
    .wr_idx_i  (addr_ctr_o[BYTE_W-1:0]),
    .wr_data_i (hold_q),
    .rd_i      (scan_q),
    .rd_idx_i  (idx_q),
    .rd_data_o (arr_wdata_o),
    .rd_vld_o  (arr_we_o)
  );

  pgw_busy_timer #(.LEN(BUSY_LEN)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .go_i   (commit),
    .busy_o (busy_o)
  );

  // R10
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);
  // R5
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(stop_i));
  // R8
  prot_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !wp_q);
  // R9
  ctr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(addr_ctr_o));
endmodule

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;
  localparam int PW = 9, BW = 6, DW = 8, BUSY = 80;
  localparam int AW = PW + BW;
  localparam int NS = 1 << BW;

  logic clk = 0, rst = 1;
  logic start_i = 0, wp_i = 0, addr_load_i = 0, data_bit_i = 0;
  logic byte_vld_i = 0, byte_ack_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] byte_i = '0;
  logic busy_o, arr_we_o;
  logic [AW-1:0] arr_addr_o, addr_ctr_o;
  logic [DW-1:0] arr_wdata_o;

  always #2 clk = ~clk;

  page_commit_ctrl #(.PAGE_W(PW), .BYTE_W(BW), .DATA_W(DW), .BUSY_CYC(BUSY)) u_page_commit_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .wp_i(wp_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .data_bit_i(data_bit_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .byte_ack_i(byte_ack_i), .stop_i(stop_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
    .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o), .addr_ctr_o(addr_ctr_o));

  int n_chk = 0, n_fail = 0;
  int got_n = 0, busy_cnt = 0, we_nobusy = 0;
  int got_a [NS];
  int got_d [NS];
  logic [DW-1:0] eb [NS];
  bit em [NS];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (busy_o) busy_cnt++;
    if (arr_we_o) begin
      if (got_n < NS) begin
        got_a[got_n] = int'(arr_addr_o);
        got_d[got_n] = int'(arr_wdata_o);
      end
      got_n++;
      if (!busy_o) we_nobusy++;
    end
  end

  task automatic pulse_start(input bit wp);
    start_i = 1; wp_i = wp; @(negedge clk); start_i = 0; wp_i = ~wp;
  endtask
  task automatic pulse_addr(input int a);
    addr_load_i = 1; addr_i = AW'(a); @(negedge clk); addr_load_i = 0;
  endtask
  task automatic send_byte(input logic [DW-1:0] d, input bit ack);
    for (int b = 0; b < 7; b++) begin data_bit_i = 1; @(negedge clk); data_bit_i = 0; end
    data_bit_i = 1; byte_vld_i = 1; byte_i = d; @(negedge clk);
    data_bit_i = 0; byte_vld_i = 0;
    if (ack) begin byte_ack_i = 1; @(negedge clk); byte_ack_i = 0; end
  endtask
  task automatic pulse_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask

  // mode 0: clean stop, 1: stop after a few bits, 2: stop after full byte without ACK
  task automatic run_txn(input bit wp, input int sa, input int n, input int mode, input string tag);
    int pg, exp_w, k;
    bit cm;
    pg = (sa / NS) % (1 << PW);
    for (int i = 0; i < NS; i++) em[i] = 0;
    pulse_start(wp);
    pulse_addr(sa);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      eb[(sa + i) % NS] = d;
      em[(sa + i) % NS] = 1;
      send_byte(d, 1);
    end
    if (mode == 1) begin
      for (int b = 0; b < 3; b++) begin data_bit_i = 1; @(negedge clk); data_bit_i = 0; end
    end else if (mode == 2) begin
      send_byte(8'h5A, 0);
    end
    wp_i = 0;
    got_n = 0; busy_cnt = 0;
    pulse_stop();
    repeat (BUSY + 8) @(negedge clk);
    cm = (n > 0) && (mode == 0) && !wp;
    exp_w = 0;
    for (int i = 0; i < NS; i++) if (cm && em[i]) exp_w++;
    check(busy_cnt == (cm ? BUSY : 0), {tag, " busy length"}, busy_cnt, cm ? BUSY : 0);
    check(got_n == exp_w, {tag, " write count"}, got_n, exp_w);
    k = 0;
    if (got_n == exp_w) begin
      for (int i = 0; i < NS; i++) begin
        if (cm && em[i]) begin
          check(got_a[k] == pg * NS + i, {tag, " R5 write addr"}, got_a[k], pg * NS + i);
          check(got_d[k] == int'(eb[i]), {tag, " R3 write data"}, got_d[k], int'(eb[i]));
          k++;
        end
      end
    end
    check(int'(addr_ctr_o) == pg * NS + (sa + n) % NS, {tag, " R3 R4 counter"},
          int'(addr_ctr_o), pg * NS + (sa + n) % NS);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F0C5));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 0, "R1 busy", busy_o, 0);
    check(arr_we_o == 0, "R1 we", arr_we_o, 0);
    check(addr_ctr_o == 0, "R1 counter", int'(addr_ctr_o), 0);

    // R2 address load, then R6 stop with nothing loaded
    pulse_start(0);
    pulse_addr(15'h2A7D);
    @(negedge clk);
    check(addr_ctr_o == 15'h2A7D, "R2 load", int'(addr_ctr_o), 'h2A7D);
    got_n = 0; busy_cnt = 0;
    pulse_stop();
    repeat (BUSY + 8) @(negedge clk);
    check(busy_cnt == 0, "R6 no busy", busy_cnt, 0);
    check(got_n == 0, "R6 no write", got_n, 0);

    // Directed cases
    run_txn(0, 5 * NS + 32, 64, 0, "R4 full page from 32");
    run_txn(0, 9 * NS + 10, 70, 0, "R4 overwrite past 64");
    run_txn(0, 3 * NS + 63, 2, 0, "R3 wrap 63->0");
    run_txn(0, 7 * NS + 5, 1, 0, "R5 single byte");
    run_txn(0, 11 * NS, 3, 1, "R7 mid-bit stop");
    run_txn(0, 12 * NS, 3, 2, "R7 unacked byte stop");
    run_txn(0, 13 * NS, 0, 0, "R6 empty");
    run_txn(1, 14 * NS + 4, 5, 0, "R8 protected");
    run_txn(0, 15 * NS + 4, 5, 0, "R8 wp rises after start");

    // R9 traffic during busy is ignored
    pulse_start(0);
    pulse_addr(20 * NS + 8);
    send_byte(8'hA1, 1);
    send_byte(8'hB2, 1);
    wp_i = 0;
    got_n = 0; busy_cnt = 0;
    pulse_stop();
    @(negedge clk);
    pulse_start(0);
    pulse_addr(21 * NS + 1);
    send_byte(8'hC3, 1);
    pulse_stop();
    check(addr_ctr_o == AW'(20 * NS + 10), "R9 counter frozen", int'(addr_ctr_o), 20 * NS + 10);
    repeat (BUSY + 8) @(negedge clk);
    check(busy_cnt == BUSY, "R9 single busy", busy_cnt, BUSY);
    check(got_n == 2, "R9 write count", got_n, 2);
    check(addr_ctr_o == AW'(20 * NS + 10), "R9 counter after", int'(addr_ctr_o), 20 * NS + 10);
    busy_cnt = 0;
    pulse_stop();
    repeat (10) @(negedge clk);
    check(busy_cnt == 0, "R9 no transaction opened", busy_cnt, 0);

    // Random transactions
    for (int t = 0; t < 30; t++) begin
      int r, md;
      r = int'($urandom % 8);
      md = (r == 0) ? 1 : ((r == 1) ? 2 : 0);
      run_txn(($urandom % 5) == 0, int'($urandom % (1 << AW)), int'($urandom % 100), md, "rnd R5");
    end

    check(we_nobusy == 0, "R10 write outside busy", we_nobusy, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule